// File: doc/BRIEF.md
# Two-Channel Serial Audio Transmitter

This block turns left and right sample words from a wide internal data bus into a two-channel serial audio stream. A processing core loads a left and a right holding register whenever it likes within a sample period, using one write strobe per channel. The most significant bits of the bus form the word. On the rising edge of the word clock, both holding registers are copied into the output path together. The pair is then shifted out MSB first against an external bit clock: the left word while the word clock is high, the right word while it is low. The stream therefore carries the previous period's data, one period late.

A two-bit format field selects the framing at run time. The choices are a 24-bit word or a 16-bit word placed at the start of the channel slot, or a 16-bit word placed at the end of the slot so that its LSB is the last bit before the word-clock transition. Slot bits outside the word are zero. The bit clock and word clock are inputs already synchronous to the system clock; the block finds their edges by sampling them.

Top module: `serial_audio_tx`

## Requirements
- R1: During and after reset `sdata` is 0 and both holding registers are cleared, so the first frame after reset carries only zero bits in both channels.
- R2: A cycle with `wr_left` (or `wr_right`) high loads that channel's holding register with bits [BUS_W-1 : BUS_W-24] of `bus_data`. When several writes happen in one period, the last one wins.
- R3: At each rising word-clock edge, both holding registers are copied into the output path. The left word is sent while `wclk` is high and the right word while it is low.
- R4: `sdata` changes only in the system-clock cycle after a falling `bclk` edge is seen. It holds steady from there until the next falling edge. Bits go out MSB first, one per bit-clock period, and the receiver samples them on the rising edge of `bclk`.
- R5: With `fmt_sel` = 2'b00 (24-bit, start of slot), slot bits 0..23 carry the 24-bit word MSB first and the remaining slot bits are 0. The reserved code 2'b11 behaves the same way.
- R6: With `fmt_sel` = 2'b01 (16-bit, start of slot), slot bits 0..15 carry `bus_data[BUS_W-1 : BUS_W-16]` MSB first and the remaining slot bits are 0.
- R7: With `fmt_sel` = 2'b10 (16-bit, end of slot), the first SLOT_W-16 slot bits are 0. The last 16 slot bits carry `bus_data[BUS_W-1 : BUS_W-16]` MSB first, so the LSB is the final bit before the word clock changes.
- R8: `fmt_sel` is sampled at the rising word-clock edge and governs both channels of that frame. A change in the middle of a frame takes effect from the next frame.
- R9: A write after the transfer edge does not alter the frame being sent. It is held and sent in the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | BUS_W | Internal data bus; word taken from its upper bits |
| wr_left | input | 1 | Load left holding register from the bus |
| wr_right | input | 1 | Load right holding register from the bus |
| fmt_sel | input | 2 | Output format: 00 24-bit start, 01 16-bit start, 10 16-bit end, 11 as 00 |
| bclk | input | 1 | Bit clock, synchronous to clk |
| wclk | input | 1 | Word clock, high for the left channel |
| sdata | output | 1 | Serial audio data |

## Verification
The bench builds the block with BUS_W = 28 and SLOT_W = 32. Because the bus is wider than 24 bits, its four lowest bits must be dropped; writing non-zero values there exposes any error in taking the word from the upper end. A 32-bit slot leaves eight padding bits after a 24-bit word and sixteen before or after a 16-bit word. This makes the zero fill and the position of the end-of-slot word visible in every format. A bit-clock period of eight system clocks leaves room for the bench to start writes and format changes partway through a frame.

// File: rtl/tx_pkg.sv
package tx_pkg;

    typedef enum logic [1:0] {
        FMT_MSB24 = 2'b00,
        FMT_MSB16 = 2'b01,
        FMT_LSB16 = 2'b10,
        FMT_RSVD  = 2'b11
    } fmt_e;

    localparam int WORD_LONG  = 24;
    localparam int WORD_SHORT = 16;

    typedef struct packed {
        logic bit_fall;   // falling bclk seen this cycle
        logic word_edge;  // first bit of a new channel half
        logic word_rise;  // first bit of the left half (transfer point)
    } edge_s;

    function automatic logic [WORD_SHORT-1:0] short_of(input logic [WORD_LONG-1:0] w);
        return w[WORD_LONG-1 -: WORD_SHORT];
    endfunction

endpackage

// File: rtl/tx_edge_detect.sv
module tx_edge_detect
    import tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bclk,
    input  logic  wclk,
    output edge_s ev
);
    logic bclk_d;
    logic wclk_seen;

    always_comb begin
        ev.bit_fall  = bclk_d & ~bclk;
        ev.word_edge = ev.bit_fall & (wclk != wclk_seen);
        ev.word_rise = ev.word_edge & wclk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d    <= 1'b1;
            wclk_seen <= 1'b0;
        end else begin
            bclk_d <= bclk;
            if (ev.bit_fall)
                wclk_seen <= wclk;
        end
    end
endmodule

// File: rtl/tx_hold.sv
module tx_hold
    import tx_pkg::*;
#(
    parameter int BUS_W = 28
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BUS_W-1:0]     bus_data,
    input  logic                 wr,
    output logic [WORD_LONG-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else if (wr)
            word <= bus_data[BUS_W-1 -: WORD_LONG];
    end
endmodule

// File: rtl/tx_slot_fmt.sv
module tx_slot_fmt
    import tx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic [1:0]           fmt_sel,
    input  logic [WORD_LONG-1:0] word,
    output logic [SLOT_W-1:0]    slot
);
    always_comb begin
        slot = '0;
        case (fmt_e'(fmt_sel))
            FMT_MSB16: slot[SLOT_W-1 -: WORD_SHORT] = short_of(word);
            FMT_LSB16: slot[WORD_SHORT-1:0]         = short_of(word);
            default:   slot[SLOT_W-1 -: WORD_LONG]  = word;
        endcase
    end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import tx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  edge_s             ev,
    input  logic [SLOT_W-1:0] slot_l,
    input  logic [SLOT_W-1:0] slot_r,
    output logic              sdata
);
    logic [SLOT_W-1:0] sh;
    logic [SLOT_W-1:0] shadow_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            shadow_r <= '0;
            sdata    <= 1'b0;
        end else if (ev.bit_fall) begin
            if (ev.word_rise) begin
                sdata    <= slot_l[SLOT_W-1];
                sh       <= {slot_l[SLOT_W-2:0], 1'b0};
                shadow_r <= slot_r;
            end else if (ev.word_edge) begin
                sdata <= shadow_r[SLOT_W-1];
                sh    <= {shadow_r[SLOT_W-2:0], 1'b0};
            end else begin
                sdata <= sh[SLOT_W-1];
                sh    <= {sh[SLOT_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import tx_pkg::*;
#(
    parameter int BUS_W  = 28,
    parameter int SLOT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_data,
    input  logic             wr_left,
    input  logic             wr_right,
    input  logic [1:0]       fmt_sel,
    input  logic             bclk,
    input  logic             wclk,
    output logic             sdata
);
    localparam int NCH = 2;

    edge_s                ev;
    logic [NCH-1:0]       wr_vec;
    logic [WORD_LONG-1:0] word [NCH];
    logic [SLOT_W-1:0]    slot [NCH];

    assign wr_vec = {wr_right, wr_left};

    tx_edge_detect u_edge (
        .clk  (clk),
        .rst  (rst),
        .bclk (bclk),
        .wclk (wclk),
        .ev   (ev)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        tx_hold #(.BUS_W(BUS_W)) u_hold (
            .clk      (clk),
            .rst      (rst),
            .bus_data (bus_data),
            .wr       (wr_vec[ch]),
            .word     (word[ch])
        );
        tx_slot_fmt #(.SLOT_W(SLOT_W)) u_fmt (
            .fmt_sel (fmt_sel),
            .word    (word[ch]),
            .slot    (slot[ch])
        );
    end

    tx_serializer #(.SLOT_W(SLOT_W)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .slot_l (slot[0]),
        .slot_r (slot[1]),
        .sdata  (sdata)
    );
endmodule

// File: rtl/tx_checker.sv
module tx_checker #(
    parameter int SLOT_W = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       bclk,
    input logic       wclk,
    input logic [1:0] fmt_sel,
    input logic       sdata
);
    localparam int IW = $clog2(SLOT_W) + 2;

    logic          bclk_c;
    logic          wseen_c;
    logic [IW-1:0] idx_q;
    logic [1:0]    fmt_q;
    logic          fall;
    logic          edge_w;
    logic [IW-1:0] cur_idx;
    logic [1:0]    cur_fmt;

    always_comb begin
        fall    = bclk_c & ~bclk;
        edge_w  = fall & (wclk != wseen_c);
        cur_idx = edge_w ? '0 : ((&idx_q) ? idx_q : idx_q + 1'b1);
        cur_fmt = (edge_w & wclk) ? fmt_sel : fmt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_c  <= 1'b1;
            wseen_c <= 1'b0;
            idx_q   <= '0;
            fmt_q   <= 2'b00;
        end else begin
            bclk_c <= bclk;
            if (fall) begin
                wseen_c <= wclk;
                idx_q   <= cur_idx;
                fmt_q   <= cur_fmt;
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (sdata == 1'b0));

    p_change_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (sdata != $past(sdata)) |-> ($past(bclk_c) && !$past(bclk)));

    p_pad_long_r5: assert property (@(posedge clk) disable iff (rst)
        (fall && (cur_fmt == 2'b00 || cur_fmt == 2'b11) && cur_idx >= IW'(24))
        |=> (sdata == 1'b0));

    p_pad_short_r6: assert property (@(posedge clk) disable iff (rst)
        (fall && cur_fmt == 2'b01 && cur_idx >= IW'(16)) |=> (sdata == 1'b0));

    p_lead_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (fall && cur_fmt == 2'b10 && cur_idx < IW'(SLOT_W - 16)) |=> (sdata == 1'b0));
endmodule

bind serial_audio_tx tx_checker #(.SLOT_W(SLOT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bclk    (bclk),
    .wclk    (wclk),
    .fmt_sel (fmt_sel),
    .sdata   (sdata)
);

// File: tb/test_serial_audio_tx.sv
module test_serial_audio_tx;
    localparam int BUS_W  = 28;
    localparam int SLOT_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [BUS_W-1:0] bus_data = '0;
    logic             wr_left = 1'b0;
    logic             wr_right = 1'b0;
    logic [1:0]       fmt_sel = 2'b00;
    logic             bclk = 1'b1;
    logic             wclk = 1'b0;
    logic             sdata;

    int checks = 0;
    int errors = 0;
    int unstable = 0;
    bit done = 0;

    always #4 clk = ~clk;

    serial_audio_tx #(.BUS_W(BUS_W), .SLOT_W(SLOT_W)) i_serial_audio_tx (
        .clk      (clk),
        .rst      (rst),
        .bus_data (bus_data),
        .wr_left  (wr_left),
        .wr_right (wr_right),
        .fmt_sel  (fmt_sel),
        .bclk     (bclk),
        .wclk     (wclk),
        .sdata    (sdata)
    );

    function automatic logic [SLOT_W-1:0] exp_slot(input logic [1:0] f, input logic [BUS_W-1:0] b);
        logic [SLOT_W-1:0] s = '0;
        case (f)
            2'b01:   s[SLOT_W-1 -: 16] = b[BUS_W-1 -: 16];
            2'b10:   s[15:0]           = b[BUS_W-1 -: 16];
            default: s[SLOT_W-1 -: 24] = b[BUS_W-1 -: 24];
        endcase
        return s;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write(input bit right, input logic [BUS_W-1:0] v);
        @(negedge clk);
        bus_data = v;
        if (right) wr_right = 1'b1; else wr_left = 1'b1;
        @(negedge clk);
        wr_left  = 1'b0;
        wr_right = 1'b0;
    endtask

    task automatic play_frame(output logic [SLOT_W-1:0] l, output logic [SLOT_W-1:0] r);
        logic a;
        for (int h = 0; h < 2; h++) begin
            for (int i = 0; i < SLOT_W; i++) begin
                @(negedge clk);
                bclk = 1'b0;
                wclk = (h == 0);
                repeat (4) @(negedge clk);
                bclk = 1'b1;
                a = sdata;
                if (h == 0) l[SLOT_W-1-i] = a; else r[SLOT_W-1-i] = a;
                repeat (3) @(negedge clk);
                if (sdata !== a) unstable++;
            end
        end
    endtask

    task automatic t_reset();
        logic [SLOT_W-1:0] l, r;
        check("R1 sdata in reset", 64'(sdata), 64'd0);
        play_frame(l, r);
        check("R1 first left", 64'(l), 64'd0);
        check("R1 first right", 64'(r), 64'd0);
    endtask

    task automatic t_format(input logic [1:0] f, input string req,
                            input logic [BUS_W-1:0] vl, input logic [BUS_W-1:0] vr);
        logic [SLOT_W-1:0] l, r;
        fmt_sel = f;
        write(0, vl);
        write(1, vr);
        play_frame(l, r);
        check({req, " left"}, 64'(l), 64'(exp_slot(f, vl)));
        check({req, " right (R3)"}, 64'(r), 64'(exp_slot(f, vr)));
    endtask

    task automatic t_last_write();
        logic [SLOT_W-1:0] l, r;
        fmt_sel = 2'b00;
        write(0, 28'h1111111);
        write(0, 28'h2468ACE);
        write(1, 28'h7654321);
        play_frame(l, r);
        check("R2 last write wins", 64'(l), 64'(exp_slot(2'b00, 28'h2468ACE)));
        check("R2 right load", 64'(r), 64'(exp_slot(2'b00, 28'h7654321)));
    endtask

    task automatic t_late_write();
        logic [SLOT_W-1:0] l, r;
        fmt_sel = 2'b00;
        write(0, 28'hA5A5A5A);
        write(1, 28'h5A5A5A5);
        fork
            play_frame(l, r);
            begin
                repeat (100) @(negedge clk);
                write(0, 28'h0F0F0F3);
                repeat (200) @(negedge clk);
                write(1, 28'hC3C3C3C);
            end
        join
        check("R9 left unchanged this frame", 64'(l), 64'(exp_slot(2'b00, 28'hA5A5A5A)));
        check("R9 right unchanged this frame", 64'(r), 64'(exp_slot(2'b00, 28'h5A5A5A5)));
        play_frame(l, r);
        check("R9 left next frame", 64'(l), 64'(exp_slot(2'b00, 28'h0F0F0F3)));
        check("R9 right next frame", 64'(r), 64'(exp_slot(2'b00, 28'hC3C3C3C)));
    endtask

    task automatic t_fmt_change();
        logic [SLOT_W-1:0] l, r;
        fmt_sel = 2'b00;
        write(0, 28'hFEDCBA9);
        write(1, 28'h13579BD);
        fork
            play_frame(l, r);
            begin
                repeat (60) @(negedge clk);
                fmt_sel = 2'b10;
            end
        join
        check("R8 old format left", 64'(l), 64'(exp_slot(2'b00, 28'hFEDCBA9)));
        check("R8 old format right", 64'(r), 64'(exp_slot(2'b00, 28'h13579BD)));
        play_frame(l, r);
        check("R8 new format left", 64'(l), 64'(exp_slot(2'b10, 28'hFEDCBA9)));
        check("R8 new format right", 64'(r), 64'(exp_slot(2'b10, 28'h13579BD)));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 sdata during reset", 64'(sdata), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_format(2'b00, "R5 24-bit start", 28'hABCDEF5, 28'h123456F);
        t_format(2'b01, "R6 16-bit start", 28'hBEEF123, 28'hC0DE987);
        t_format(2'b10, "R7 16-bit end", 28'h8001FFF, 28'h7FFE00A);
        t_format(2'b11, "R5 reserved code", 28'h9876543, 28'h0000FF1);
        t_last_write();
        t_late_write();
        t_fmt_change();
        check("R4 sdata stable between falls", 64'(unstable), 64'd0);
        finish_run();
    end
endmodule